// File: doc/BRIEF.md
# Capture Window Crop, Halving and Frame Decimation

This block sits directly on a raw camera pixel stream and trims it in one pass. Each incoming pixel carries a valid qualifier plus frame-start and line-start markers. The block first cuts a programmable rectangle out of every frame. It then optionally throws away every second column and/or every second row of that rectangle, each axis chosen on its own. Finally it removes whole frames according to a short repeating drop pattern, which lowers the frame rate.

The result is a new pixel stream with its own valid, frame-start and line-start markers. It is delayed one clock from the input and can feed a memory writer or a further processing stage. All settings are captured on the first pixel of each frame, so software can rewrite them at any time without tearing the frame in flight.

Top module: `capture_window_decim`

## Requirements
- R1: While reset is held and after its release with no input, `outValid`, `outSof` and `outSol` are low.
- R2: A pixel at input column x, line y is forwarded only when cropX <= x < cropX+cropW and cropY <= y < cropY+cropH. Forwarded pixels keep their input order, and each appears on the output exactly one clock after the cycle it was accepted.
- R3: With `halfH` set, only pixels whose column offset from cropX is even are forwarded.
- R4: With `halfV` set, only lines whose line offset from cropY is even are forwarded.
- R5: The output frame is ceil(cropW/2) or cropW pixels wide and ceil(cropH/2) or cropH lines tall, depending on halving. For example, an 8x6 crop halved on both axes gives 4x3, and with no halving the output rectangle equals the crop rectangle.
- R6: `outSol` is high with the first forwarded pixel of every output line, and `outSof` is high (together with `outSol`) only with the first forwarded pixel of the frame.
- R7: A 3-bit `skipPeriod` P sets a pattern length L: L=1 for P=0, L=6 for P>=6, and L=P otherwise. A position counter starts at 0 after reset. At each frame start it uses position pos (or 0 if pos >= L), drops the frame when `skipMask[pos]` is 1, then advances to pos+1, wrapping to 0 at L. For example, P=2 with mask 6'b000010 drops every second frame.
- R8: A dropped frame produces no `outValid`, `outSol` or `outSof` at all.
- R9: The crop, halving and skip inputs are sampled only on the frame-start pixel. A change made in the middle of a frame first takes effect on the next frame.
- R10: Input cycles with `inValid` low are ignored entirely, including any `inSof`/`inSol` values on them, and do not advance the column or line position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel qualifier |
| inSof | input | 1 | First pixel of an input frame (also starts a line) |
| inSol | input | 1 | First pixel of an input line |
| inData | input | DATA_W | Input pixel |
| cropX | input | COORD_W | Crop left column |
| cropY | input | COORD_W | Crop top line |
| cropW | input | COORD_W | Crop width in pixels |
| cropH | input | COORD_W | Crop height in lines |
| halfH | input | 1 | Keep every second column |
| halfV | input | 1 | Keep every second line |
| skipMask | input | 6 | Per-position frame drop bits |
| skipPeriod | input | 3 | Drop pattern length code |
| outValid | output | 1 | Output pixel qualifier |
| outSof | output | 1 | First output pixel of a frame |
| outSol | output | 1 | First output pixel of a line |
| outData | output | DATA_W | Output pixel |

## Verification
The hardest situation to reach is a configuration rewrite landing inside a frame that is being passed through. It has to be shown both that the running frame keeps its old window and halving, and that the following frame picks up the new values. The stimulus changes the crop and halving inputs on the first pixel of a middle line. It compares that frame against a model built from the old settings and the next frame against the new ones. A second hard spot is the frame-drop position counter, which carries over from frame to frame. The bench runs all earlier scenarios with a pattern length of one, so it knows the counter is at zero. It then runs two multi-frame sequences with different lengths and masks and checks the kept/dropped pattern frame by frame.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  // frame drop pattern geometry
  parameter int SKIP_LEN = 6;
  parameter int SKIP_PW  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic keep;        // forward this input pixel
    logic lineFirst;   // first kept pixel of its output line
    logic frameFirst;  // first kept pixel of the output frame
  } cwd_strb_t;
endpackage

// File: rtl/cwd_skip_seq.sv
module cwd_skip_seq
  import cwd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStart,
  input  logic [SKIP_LEN-1:0] skipMask,
  input  logic [SKIP_PW-1:0]  skipPeriod,
  output logic                dropNow
);
  localparam int PW1 = SKIP_PW + 1;

  logic [SKIP_PW-1:0] pos;
  logic [SKIP_PW-1:0] lenEff;
  logic [SKIP_PW-1:0] effPos;
  logic [SKIP_PW-1:0] nextPos;

  always_comb begin
    if (skipPeriod == '0)
      lenEff = SKIP_PW'(1);
    else if (32'(skipPeriod) >= SKIP_LEN)
      lenEff = SKIP_PW'(SKIP_LEN);
    else
      lenEff = skipPeriod;
    effPos = (pos >= lenEff) ? '0 : pos;
    if (({1'b0, effPos} + PW1'(1)) >= {1'b0, lenEff})
      nextPos = '0;
    else
      nextPos = effPos + SKIP_PW'(1);
    dropNow = skipMask[effPos];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pos <= '0;
    else if (frameStart)
      pos <= nextPos;
  end

  a_r7_pos_in_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(pos) < SKIP_LEN);
endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl
  import cwd_pkg::*;
#(
  parameter int COORD_W = 12
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inSof,
  input  logic               inSol,
  input  logic [COORD_W-1:0] cropX,
  input  logic [COORD_W-1:0] cropY,
  input  logic [COORD_W-1:0] cropW,
  input  logic [COORD_W-1:0] cropH,
  input  logic               halfH,
  input  logic               halfV,
  input  logic               dropNow,
  output logic               frameStart,
  output cwd_strb_t          strb
);
  localparam int CW1 = COORD_W + 1;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] w;
    logic [COORD_W-1:0] h;
    logic               hh;
    logic               hv;
  } win_t;

  win_t winIn, winLat, winUse;
  logic dropLat, dropUse;
  logic [COORD_W-1:0] xNext, yCur;
  logic [COORD_W-1:0] curX, curY, relX, relY;
  logic lineStart, insideX, insideY, pickX, pickY;

  always_comb begin
    winIn      = '{x: cropX, y: cropY, w: cropW, h: cropH, hh: halfH, hv: halfV};
    frameStart = inValid & inSof;
    lineStart  = inValid & (inSol | inSof);
    winUse     = frameStart ? winIn : winLat;
    dropUse    = frameStart ? dropNow : dropLat;

    curX = lineStart ? '0 : xNext;
    if (frameStart)
      curY = '0;
    else if (lineStart)
      curY = yCur + COORD_W'(1);
    else
      curY = yCur;

    relX = curX - winUse.x;
    relY = curY - winUse.y;
    insideX = ({1'b0, curX} >= {1'b0, winUse.x}) &&
              ({1'b0, curX} < ({1'b0, winUse.x} + {1'b0, winUse.w}));
    insideY = ({1'b0, curY} >= {1'b0, winUse.y}) &&
              ({1'b0, curY} < ({1'b0, winUse.y} + {1'b0, winUse.h}));
    pickX = !winUse.hh || !relX[0];
    pickY = !winUse.hv || !relY[0];

    strb.keep       = inValid & insideX & insideY & pickX & pickY & !dropUse;
    strb.lineFirst  = (relX == '0);
    strb.frameFirst = (relX == '0) && (relY == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xNext   <= '0;
      yCur    <= '0;
      winLat  <= '0;
      dropLat <= 1'b0;
    end else if (inValid) begin
      xNext <= curX + COORD_W'(1);
      yCur  <= curY;
      if (frameStart) begin
        winLat  <= winIn;
        dropLat <= dropNow;
      end
    end
  end

  // settings held for the whole frame once captured
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameStart) |-> $stable(winLat) && $stable(dropLat));

  // a cycle without a valid pixel never produces a kept pixel
  a_r10_idle_no_keep: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !strb.keep);

  // the unused width bit of the extended sums is intentional
  logic unusedCw;
  assign unusedCw = ^{CW1'(0)};
endmodule

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  cwd_strb_t         strb,
  output logic              outValid,
  output logic              outSof,
  output logic              outSol,
  output logic [DATA_W-1:0] outData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outSol   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.keep;
      outSol   <= strb.keep & strb.lineFirst;
      outSof   <= strb.keep & strb.frameFirst;
      if (strb.keep)
        outData <= inData;
    end
  end

  a_r6_sof_with_sol: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outSol && outValid);

  a_r2_data_only_on_keep: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.keep) |-> $stable(outData));
endmodule

// File: rtl/capture_window_decim.sv
module capture_window_decim
  import cwd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COORD_W = 12
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSof,
  input  logic                inSol,
  input  logic [DATA_W-1:0]   inData,
  input  logic [COORD_W-1:0]  cropX,
  input  logic [COORD_W-1:0]  cropY,
  input  logic [COORD_W-1:0]  cropW,
  input  logic [COORD_W-1:0]  cropH,
  input  logic                halfH,
  input  logic                halfV,
  input  logic [SKIP_LEN-1:0] skipMask,
  input  logic [SKIP_PW-1:0]  skipPeriod,
  output logic                outValid,
  output logic                outSof,
  output logic                outSol,
  output logic [DATA_W-1:0]   outData
);
  cwd_strb_t strb;
  logic frameStart, dropNow;

  cwd_skip_seq skipSeq_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .skipMask(skipMask), .skipPeriod(skipPeriod), .dropNow(dropNow)
  );

  cwd_ctrl #(.COORD_W(COORD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .cropX(cropX), .cropY(cropY), .cropW(cropW), .cropH(cropH),
    .halfH(halfH), .halfV(halfV), .dropNow(dropNow),
    .frameStart(frameStart), .strb(strb)
  );

  cwd_datapath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .outValid(outValid), .outSof(outSof), .outSol(outSol), .outData(outData)
  );

  a_r10_out_needs_in: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

// File: tb/capture_window_decim_tb.sv
module capture_window_decim_tb_top;
  localparam int DATA_W = 16;
  localparam int COORD_W = 12;
  localparam int FW = 16;
  localparam int FH = 12;
  localparam int MAXN = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inSol = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic [COORD_W-1:0] cropX = '0, cropY = '0, cropW = '0, cropH = '0;
  logic halfH = 1'b0, halfV = 1'b0;
  logic [5:0] skipMask = '0;
  logic [2:0] skipPeriod = 3'd1;
  logic outValid, outSof, outSol;
  logic [DATA_W-1:0] outData;

  always #10 clk = ~clk;

  capture_window_decim #(.DATA_W(DATA_W), .COORD_W(COORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inSol(inSol),
    .inData(inData), .cropX(cropX), .cropY(cropY), .cropW(cropW), .cropH(cropH),
    .halfH(halfH), .halfV(halfV), .skipMask(skipMask), .skipPeriod(skipPeriod),
    .outValid(outValid), .outSof(outSof), .outSol(outSol), .outData(outData)
  );

  int nChecks = 0;
  int nFails = 0;

  // capture of the output stream
  logic capOn = 1'b0;
  int capN = 0;
  int markN = 0;
  logic [DATA_W-1:0] capData [MAXN];
  logic capSol [MAXN];
  logic capSof [MAXN];

  // expected stream
  int expN = 0;
  int expMark = 0;
  logic [DATA_W-1:0] expData [MAXN];
  logic expSol [MAXN];
  logic expSof [MAXN];

  // mid-frame config change (row index, -1 = none)
  int changeRow = -1;
  int altX, altY, altW, altH;
  logic altHH, altHV;

  always @(negedge clk) begin
    if (capOn) begin
      if (outSof || outSol) markN++;
      if (outValid && capN < MAXN) begin
        capData[capN] = outData;
        capSol[capN]  = outSol;
        capSof[capN]  = outSof;
        capN++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int x, input int y, input int w, input int h,
                        input bit hh, input bit hv);
    cropX = COORD_W'(x); cropY = COORD_W'(y);
    cropW = COORD_W'(w); cropH = COORD_W'(h);
    halfH = hh; halfV = hv;
  endtask

  task automatic buildExp(input int x0, input int y0, input int w, input int h,
                          input bit hh, input bit hv, input bit dropped);
    expN = 0; expMark = 0;
    if (!dropped) begin
      for (int y = 0; y < FH; y++) begin
        for (int x = 0; x < FW; x++) begin
          if (x >= x0 && x < x0 + w && y >= y0 && y < y0 + h &&
              (!hh || ((x - x0) % 2 == 0)) && (!hv || ((y - y0) % 2 == 0))) begin
            expData[expN] = {8'(y), 8'(x)};
            expSol[expN]  = (x == x0);
            expSof[expN]  = (x == x0) && (y == y0);
            if (x == x0) expMark++;
            expN++;
          end
        end
      end
    end
  endtask

  task automatic driveFrame(input bit bubbles);
    capN = 0; markN = 0; capOn = 1'b1;
    for (int y = 0; y < FH; y++) begin
      for (int x = 0; x < FW; x++) begin
        if (bubbles && ((x + y) % 3 == 1)) begin
          @(negedge clk);
          inValid = 1'b0; inSof = 1'b1; inSol = 1'b1; inData = 16'hDEAD;
        end
        @(negedge clk);
        if (y == changeRow && x == 0)
          setCfg(altX, altY, altW, altH, altHH, altHV);
        inValid = 1'b1;
        inSof = (x == 0 && y == 0);
        inSol = (x == 0);
        inData = {8'(y), 8'(x)};
      end
      @(negedge clk);
      inValid = 1'b0; inSof = 1'b0; inSol = 1'b0;
    end
    repeat (3) @(negedge clk);
    capOn = 1'b0;
  endtask

  task automatic compareFrame(input string req);
    int bad = 0;
    check(capN == expN, {req, " pixel count"}, capN, expN);
    check(markN == expMark, {req, " marker count"}, markN, expMark);
    for (int i = 0; i < expN && i < capN; i++)
      if (capData[i] !== expData[i] || capSol[i] !== expSol[i] || capSof[i] !== expSof[i])
        bad++;
    check(bad == 0, {req, " stream content"}, bad, 0);
  endtask

  task automatic runFrame(input int x, input int y, input int w, input int h,
                          input bit hh, input bit hv, input bit dropped,
                          input bit bubbles, input string req);
    setCfg(x, y, w, h, hh, hv);
    buildExp(x, y, w, h, hh, hv, dropped);
    driveFrame(bubbles);
    compareFrame(req);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(!outValid && !outSof && !outSol, "R1 outputs during reset",
          int'({outValid, outSof, outSol}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !outSof && !outSol, "R1 outputs after reset",
          int'({outValid, outSof, outSol}), 0);
  endtask

  task automatic t_crop();
    runFrame(3, 2, 6, 4, 0, 0, 0, 0, "R2 R5 R6 plain crop");
    check(expN == 24, "R5 unhalved size equals crop", expN, 24);
    runFrame(0, 0, FW, FH, 0, 0, 0, 0, "R2 full window");
    runFrame(12, 9, 8, 8, 0, 0, 0, 0, "R2 window clipped at frame edge");
  endtask

  task automatic t_halving();
    runFrame(3, 2, 6, 4, 1, 0, 0, 0, "R3 horizontal halving");
    runFrame(3, 1, 6, 5, 0, 1, 0, 0, "R4 vertical halving");
    runFrame(2, 3, 8, 6, 1, 1, 0, 0, "R5 both axes halved");
    check(capN == 12, "R5 8x6 halved gives 4x3", capN, 12);
  endtask

  task automatic t_bubbles();
    runFrame(1, 1, 9, 7, 1, 0, 0, 1, "R10 idle cycles with stray markers");
  endtask

  task automatic t_midframe();
    altX = 0; altY = 0; altW = 4; altH = 4; altHH = 1'b1; altHV = 1'b0;
    changeRow = 3;
    runFrame(2, 1, 5, 6, 0, 0, 0, 0, "R9 old settings kept in running frame");
    changeRow = -1;
    buildExp(0, 0, 4, 4, 1, 0, 0);
    driveFrame(0);
    compareFrame("R9 new settings on next frame");
  endtask

  task automatic t_skip();
    skipMask = 6'b000010; skipPeriod = 3'd2;
    runFrame(3, 2, 6, 4, 0, 0, 0, 0, "R7 period 2 position 0 kept");
    runFrame(3, 2, 6, 4, 0, 0, 1, 0, "R8 period 2 position 1 dropped");
    runFrame(3, 2, 6, 4, 0, 0, 0, 0, "R7 period 2 wraps to kept");
    runFrame(3, 2, 6, 4, 0, 0, 1, 0, "R8 period 2 dropped again");
    skipMask = 6'b000110; skipPeriod = 3'd3;
    runFrame(3, 2, 6, 4, 1, 1, 0, 0, "R7 period 3 position 0 kept");
    runFrame(3, 2, 6, 4, 1, 1, 1, 0, "R8 period 3 position 1 dropped");
    runFrame(3, 2, 6, 4, 1, 1, 1, 0, "R8 period 3 position 2 dropped");
    runFrame(3, 2, 6, 4, 1, 1, 0, 0, "R7 period 3 wraps to kept");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_crop();
    t_halving();
    t_bubbles();
    t_midframe();
    t_skip();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule